// File: doc/BRIEF.md
# Reset Sequencer with Cause Register

This block sits on the raw oscillator clock of a small microcontroller and turns reset requests into one timed reset sequence. A power-on pulse starts the longest form. For a fixed settling window the internal reset is held, the clock enable for the CPU and peripherals stays low, and the reset pin is pulled low. Two equal phases follow. In the first, clocks run while reset and the pin pull-down are still held. In the second, the pin is released but the internal reset is still held. The core then leaves reset, and a one-cycle flag tells the CPU to fetch its reset vector from 0xFFFE/0xFFFF, high byte first.

Once the core is running, three more sources can restart the sequence: a watchdog timeout, an illegal-instruction detect, and an outside low level on the reset pin. These sources skip the settling window and run only the two phases. A 4-bit cause register records which source or sources started the most recent sequence. It holds that value until the next reset event replaces it.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_pulse` is high (asynchronous), `core_rst`=1, `clk_enable`=0, `pin_pull_low`=1, `vec_fetch`=0 and `cause`=4'b0001. Cause bits are: bit0 power-on, bit1 watchdog, bit2 illegal opcode, bit3 pin.
- R2: After `por_pulse` falls, `clk_enable` stays 0 for exactly STAB_CYCLES (default 4096) rising clock edges. From that edge on it is 1.
- R3: After the settling window, the first phase lasts PHASE_CYCLES (default 32) edges with `core_rst`=1 and `pin_pull_low`=1. The second phase lasts PHASE_CYCLES edges with `core_rst`=1 and `pin_pull_low`=0.
- R4: `core_rst` falls on the edge that ends the second phase. That is STAB_CYCLES+2*PHASE_CYCLES edges after power-on release. `vec_fetch` is 1 for exactly that first running cycle.
- R5: While running, `wdog_timeout` high at an edge enters the first phase on that edge, with `cause`=4'b0010.
- R6: While running, `bad_opcode` high at an edge enters the first phase on that edge, with `cause`=4'b0100.
- R7: `pin_rst_n_in` passes through a two-flop synchronizer. A low level while running enters the first phase on the third edge after it is applied, with `cause`=4'b1000. The block's own pull-down never sets the pin bit.
- R8: Requests present at the same edge all set their bits, for example watchdog with illegal opcode giving 4'b0110.
- R9: Requests that arrive while a sequence is in progress are ignored. They change neither `cause` nor the release timing.
- R10: `cause` holds while the core runs and is replaced only by the next reset event. A power-on resets it to 4'b0001, clearing every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock |
| por_pulse | input | 1 | Power-on pulse, active high, asynchronous |
| wdog_timeout | input | 1 | Watchdog timeout request |
| bad_opcode | input | 1 | Illegal-instruction detect |
| pin_rst_n_in | input | 1 | Sensed level of the reset pin, low = asserted |
| core_rst | output | 1 | Internal reset, active high |
| pin_pull_low | output | 1 | Enable for the open-drain pull-down on the reset pin |
| clk_enable | output | 1 | Clock gate for CPU and peripherals |
| vec_fetch | output | 1 | One-cycle request to fetch the reset vector |
| cause | output | 4 | Cause register of the most recent reset |

## Verification
A power-on run tells the settling window apart from the two phases by sampling one edge before and one edge after each boundary. A watchdog pulse during the second phase checks that in-sequence requests neither alter the cause nor move the release. A table then tries single watchdog, single illegal-opcode, combined watchdog and opcode, single pin, and watchdog with pin. These separate the one-edge internal latency from the three-edge pin latency, and show bit merging against first-come ignoring. A closing power-on shows that a stale watchdog cause is cleared back to the power-on bit alone.

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int STAB_CYCLES  = 4096,
  parameter int PHASE_CYCLES = 32
) (
  input  logic       clk_osc,
  input  logic       por_pulse,
  input  logic       wdog_timeout,
  input  logic       bad_opcode,
  input  logic       pin_rst_n_in,
  output logic       core_rst,
  output logic       pin_pull_low,
  output logic       clk_enable,
  output logic       vec_fetch,
  output logic [3:0] cause
);
  localparam int MAXLEN = (STAB_CYCLES > PHASE_CYCLES) ? STAB_CYCLES : PHASE_CYCLES;
  localparam int CW     = $clog2(MAXLEN + 1);

  typedef enum logic [1:0] {S_STAB, S_PH1, S_PH2, S_RUN} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [1:0]    pin_s;
  logic          last;
  logic [3:0]    req;

  assign last = (state == S_STAB) ? (cnt == CW'(STAB_CYCLES - 1))
                                  : (cnt == CW'(PHASE_CYCLES - 1));
  assign req  = {~pin_s[1], bad_opcode, wdog_timeout, 1'b0};

  assign core_rst     = (state != S_RUN);
  assign clk_enable   = (state != S_STAB);
  assign pin_pull_low = (state == S_STAB) || (state == S_PH1);

  always_ff @(posedge clk_osc or posedge por_pulse) begin
    if (por_pulse) begin
      state     <= S_STAB;
      cnt       <= '0;
      cause     <= 4'b0001;
      pin_s     <= 2'b11;
      vec_fetch <= 1'b0;
    end else begin
      pin_s     <= {pin_s[0], pin_rst_n_in};
      vec_fetch <= 1'b0;
      if (state == S_RUN) begin
        if (req != 4'b0000) begin
          state <= S_PH1;
          cnt   <= '0;
          cause <= req;
        end
      end else if (last) begin
        cnt <= '0;
        case (state)
          S_STAB:  state <= S_PH1;
          S_PH1:   state <= S_PH2;
          default: begin
            state     <= S_RUN;
            vec_fetch <= 1'b1;
          end
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk (
  input logic       clk_osc,
  input logic       por_pulse,
  input logic       wdog_timeout,
  input logic       bad_opcode,
  input logic       core_rst,
  input logic       pin_pull_low,
  input logic       clk_enable,
  input logic       vec_fetch,
  input logic [3:0] cause
);
  a_r2_gated_in_reset: assert property (@(posedge clk_osc) disable iff (por_pulse)
    !clk_enable |-> (core_rst && pin_pull_low));

  a_r3_pull_within_reset: assert property (@(posedge clk_osc) disable iff (por_pulse)
    pin_pull_low |-> core_rst);

  a_r4_vec_single: assert property (@(posedge clk_osc) disable iff (por_pulse)
    vec_fetch |=> !vec_fetch);

  a_r4_vec_at_release: assert property (@(posedge clk_osc) disable iff (por_pulse)
    vec_fetch |-> (!core_rst && $past(core_rst)));

  a_r5_wdog_enters: assert property (@(posedge clk_osc) disable iff (por_pulse)
    (!core_rst && wdog_timeout) |=> (core_rst && pin_pull_low && cause[1]));

  a_r6_opcode_enters: assert property (@(posedge clk_osc) disable iff (por_pulse)
    (!core_rst && bad_opcode) |=> (core_rst && pin_pull_low && cause[2]));

  a_r10_cause_held: assert property (@(posedge clk_osc) disable iff (por_pulse)
    (!core_rst && $past(!core_rst)) |-> $stable(cause));
endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
  .clk_osc(clk_osc), .por_pulse(por_pulse), .wdog_timeout(wdog_timeout),
  .bad_opcode(bad_opcode), .core_rst(core_rst), .pin_pull_low(pin_pull_low),
  .clk_enable(clk_enable), .vec_fetch(vec_fetch), .cause(cause)
);

// File: tb/rst_sequencer_tb.sv
module rst_sequencer_tb;
  localparam int PERIOD = 10;
  localparam int STAB   = 4096;
  localparam int PHASE  = 32;
  // {wdog, opcode, pin, latency[2:0], expected cause[3:0]}
  localparam logic [9:0] VEC [5] = '{
    10'b100_001_0010,
    10'b010_001_0100,
    10'b110_001_0110,
    10'b001_011_1000,
    10'b101_001_0010
  };

  logic clk = 1'b0, por = 1'b1, wdog = 1'b0, bad = 1'b0, ext = 1'b0;
  logic core_rst, pull, clk_en, vec;
  logic [3:0] cause;
  int runs = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  rst_sequencer #(.STAB_CYCLES(STAB), .PHASE_CYCLES(PHASE)) u_dut (
    .clk_osc(clk), .por_pulse(por), .wdog_timeout(wdog), .bad_opcode(bad),
    .pin_rst_n_in(~(ext | pull)), .core_rst(core_rst), .pin_pull_low(pull),
    .clk_enable(clk_en), .vec_fetch(vec), .cause(cause));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog expired actual 1 expected 0");
      report();
    end
  end

  initial begin
    tick(2);
    chk("R1 reset outputs", {core_rst, clk_en, pull, vec}, 4'b1010);
    chk("R1 reset cause", cause, 4'b0001);
    por = 1'b0;
    tick(STAB - 1);
    chk("R2 clocks still gated", {3'b0, clk_en}, 4'd0);
    tick(1);
    chk("R2/R3 first phase", {1'b0, core_rst, clk_en, pull}, 4'b0111);
    tick(PHASE - 1);
    chk("R3 pull held in first phase", {3'b0, pull}, 4'd1);
    tick(1);
    chk("R3 second phase", {2'b0, core_rst, pull}, 4'b0010);
    wdog = 1'b1;
    tick(1);
    wdog = 1'b0;
    chk("R9 request ignored in sequence", cause, 4'b0001);
    tick(PHASE - 2);
    chk("R4 reset held to last cycle", {3'b0, core_rst}, 4'd1);
    tick(1);
    chk("R4 release with vector fetch", {2'b0, core_rst, vec}, 4'b0001);
    chk("R7 own pull-down sets no pin bit", cause, 4'b0001);
    tick(1);
    chk("R4 vector fetch one cycle", {3'b0, vec}, 4'd0);

    for (int i = 0; i < 5; i++) begin
      {wdog, bad, ext} = VEC[i][9:7];
      tick(1);
      {wdog, bad, ext} = 3'b000;
      for (int k = 1; k < int'(VEC[i][6:4]); k++) begin
        chk($sformatf("R7 pin latency vec%0d", i), {3'b0, core_rst}, 4'd0);
        tick(1);
      end
      chk($sformatf("R5/R6/R8 entry vec%0d", i), {2'b0, core_rst, pull}, 4'b0011);
      chk($sformatf("R5/R6/R7/R8/R9 cause vec%0d", i), cause, VEC[i][3:0]);
      tick(PHASE);
      chk($sformatf("R3 short second phase vec%0d", i), {2'b0, core_rst, pull}, 4'b0010);
      tick(PHASE);
      chk($sformatf("R4 short release vec%0d", i), {2'b0, core_rst, vec}, 4'b0001);
      tick(3);
      chk($sformatf("R10 cause held vec%0d", i), cause, VEC[i][3:0]);
    end

    por = 1'b1;
    #1;
    chk("R10 power-on clears cause", cause, 4'b0001);
    chk("R1 async gating", {3'b0, clk_en}, 4'd0);
    tick(1);
    por = 1'b0;
    tick(STAB + 2 * PHASE);
    chk("R4 full release after power-on", {2'b0, core_rst, vec}, 4'b0001);
    chk("R10 cause after power-on", cause, 4'b0001);
    done = 1;
    report();
  end
endmodule